// File: doc/BRIEF.md
# Instruction T-State Sequencer

This block paces a small processor's instructions through their T-states. Each instruction opens with a T1 state, may pass through one or two TX states and any number of TW wait states, and closes with a T2 state. The sequencer reports the current state and which half of it is running. It drives a strobe that marks the start of each instruction, a one-cycle pulse when the next instruction address should advance, and a one-cycle pulse when the instruction finishes.

The block runs on a clock at twice the T-state rate, so every T-state lasts two clock cycles and half-state events fall on clock edges. The instruction class and the programmed wait count are sampled when an instruction starts. An active-low wait input can stretch any instruction just before its T2 state, for as long as it stays low.

Top module: `instr_tstate_seq`

## Requirements
- R1: While reset is asserted, and until the first instruction starts, the outputs show T1 first half with the strobe high and both pulses low. The programmed wait setting held from reset is 3, so a first two-state instruction that uses the held setting takes 10 cycles.
- R2: `tstate` encodes T1=0, TX=1, TW=2, T2=3. Every T-state lasts exactly two cycles, with `half`=0 in the first and `half`=1 in the second, and the state changes only after a second half.
- R3: `instr_type` selects the class: 0 two-state (no TX), 1 three-state control (one TX), 2 three-state data (one TX), 3 four-state data read (two TX), 4 four-state control (two TX), 5 two-word (two words, each T1 then T2). Codes 6 and 7 behave as code 0.
- R4: `instr_strobe` is high from the start of T1 until the end of T1 for classes 0, 2, 3, 5, and until the end of the last TX for classes 1 and 4. It is low in every other state.
- R5: `addr_inc` is a one-cycle pulse in the second half of the last state in which the strobe is high.
- R6: Programmed TW states are placed directly before T2. Their count equals the setting for classes 0, 1, 4, 5. For class 2 it is the setting minus 1, and for class 3 the setting minus 2, with a floor of 0.
- R7: A two-word instruction runs two words. Each word has its own T1, its own programmed TW states, its own T2, its own strobe and its own `addr_inc`.
- R8: If `wait_n` is low in the second half of the state that would otherwise be followed by T2 (after any programmed TW), one TW state is added. This check repeats in every added TW until `wait_n` is found high.
- R9: The wait setting is sampled in the first half of each first-word T1. Classes 1, 4 and 5 use the value sampled at their own start. All other classes use the value sampled at the start of the previous instruction.
- R10: `instr_end` is a one-cycle pulse in the second half of an instruction's final T2 (for class 5, the second word's T2). The next cycle is T1 first half.
- R11: `instr_type` is sampled only in the first half of a first-word T1. Its value in every other cycle has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the T-state rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_type | input | 3 | Instruction timing class code |
| iws_set | input | WS_W (2) | Programmed instruction wait-state count |
| wait_n | input | 1 | Active-low external wait request |
| tstate | output | 2 | Current T-state code |
| half | output | 1 | 0 in the first half of a T-state, 1 in the second |
| instr_strobe | output | 1 | Instruction boundary strobe |
| addr_inc | output | 1 | Next-address pulse |
| instr_end | output | 1 | End-of-instruction pulse |

## Verification
The hardest case to reach is the two-stage delay of the wait setting. The delay only shows when the setting changes in the middle of an instruction and the next two instructions belong to different groups. The directed stimulus changes the setting a few cycles after an instruction has sampled it. It then times the following instructions for a data-path class and for a control class. A random phase changes the class code every cycle, drops `wait_n` in bursts and moves the setting at random. A behavioural queue model in the bench follows all of this and is compared with the outputs on every clock.

// File: rtl/tseq_pkg.sv
package tseq_pkg;
  localparam int CLS_W  = 3;
  localparam int MAX_TX = 2;
  localparam int TX_W   = $clog2(MAX_TX + 1);

  typedef enum logic [1:0] {
    TS_T1 = 2'd0,
    TS_TX = 2'd1,
    TS_TW = 2'd2,
    TS_T2 = 2'd3
  } tstate_e;

  localparam logic [CLS_W-1:0] CL_BASIC = 3'd0;
  localparam logic [CLS_W-1:0] CL_CTL3  = 3'd1;
  localparam logic [CLS_W-1:0] CL_DAT3  = 3'd2;
  localparam logic [CLS_W-1:0] CL_DRD4  = 3'd3;
  localparam logic [CLS_W-1:0] CL_CTL4  = 3'd4;
  localparam logic [CLS_W-1:0] CL_DUAL  = 3'd5;

  // number of TX states a class inserts between T1 and the tail
  function automatic logic [TX_W-1:0] tx_of(input logic [CLS_W-1:0] c);
    case (c)
      CL_CTL3, CL_DAT3: tx_of = TX_W'(1);
      CL_DRD4, CL_CTL4: tx_of = TX_W'(2);
      default:          tx_of = '0;
    endcase
  endfunction

  // control classes pick up a new wait setting one instruction earlier
  function automatic logic is_ctl(input logic [CLS_W-1:0] c);
    is_ctl = (c == CL_CTL3) || (c == CL_CTL4) || (c == CL_DUAL);
  endfunction

  // data classes count their TX states against the programmed waits
  function automatic logic is_data(input logic [CLS_W-1:0] c);
    is_data = (c == CL_DAT3) || (c == CL_DRD4);
  endfunction
endpackage

// File: rtl/tseq_rst_sync.sv
module tseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/tseq_wait_sel.sv
module tseq_wait_sel
  import tseq_pkg::*;
#(
  parameter int WS_W   = 2,
  parameter int WS_RST = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [CLS_W-1:0] cls_in,
  input  logic [WS_W-1:0]  ws_in,
  output logic [WS_W-1:0]  wneed
);
  logic [WS_W-1:0] ws_prev_q, ws_prev_d;
  logic [WS_W-1:0] wneed_d;
  logic [WS_W-1:0] eff;
  logic [WS_W-1:0] ded;

  always_comb begin
    eff       = is_ctl(cls_in) ? ws_in : ws_prev_q;
    ded       = is_data(cls_in) ? WS_W'(tx_of(cls_in)) : '0;
    wneed_d   = wneed;
    ws_prev_d = ws_prev_q;
    if (capture) begin
      wneed_d   = (eff > ded) ? (eff - ded) : '0;
      ws_prev_d = ws_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_prev_q <= WS_W'(WS_RST);
      wneed     <= '0;
    end else begin
      ws_prev_q <= ws_prev_d;
      wneed     <= wneed_d;
    end
  end
endmodule

// File: rtl/tseq_core.sv
module tseq_core
  import tseq_pkg::*;
#(
  parameter int WS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CLS_W-1:0] cls_in,
  input  logic             wait_n,
  input  logic [WS_W-1:0]  wneed,
  output tstate_e          state,
  output logic             half,
  output logic [TX_W-1:0]  txi,
  output logic             word,
  output logic [CLS_W-1:0] cls,
  output logic             capture
);
  tstate_e          state_d, tail_state;
  logic             half_d, word_d, tail_bump;
  logic [TX_W-1:0]  txi_d;
  logic [CLS_W-1:0] cls_d;
  logic [WS_W-1:0]  twc, twc_d;

  assign capture = (state == TS_T1) && !half && !word;

  // what follows the TX run: programmed waits, then external waits, then T2
  always_comb begin
    tail_bump = 1'b0;
    if (twc < wneed) begin
      tail_state = TS_TW;
      tail_bump  = 1'b1;
    end else if (!wait_n) begin
      tail_state = TS_TW;
    end else begin
      tail_state = TS_T2;
    end
  end

  always_comb begin
    state_d = state;
    half_d  = ~half;
    txi_d   = txi;
    word_d  = word;
    twc_d   = twc;
    cls_d   = capture ? cls_in : cls;
    if (half) begin
      unique case (state)
        TS_T1: begin
          if (tx_of(cls) != '0) begin
            state_d = TS_TX;
            txi_d   = '0;
          end else begin
            state_d = tail_state;
            twc_d   = twc + WS_W'(tail_bump);
          end
        end
        TS_TX: begin
          if ((txi + TX_W'(1)) < tx_of(cls)) begin
            txi_d = txi + TX_W'(1);
          end else begin
            state_d = tail_state;
            twc_d   = twc + WS_W'(tail_bump);
          end
        end
        TS_TW: begin
          state_d = tail_state;
          twc_d   = twc + WS_W'(tail_bump);
        end
        TS_T2: begin
          state_d = TS_T1;
          twc_d   = '0;
          word_d  = (cls == CL_DUAL) && !word;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TS_T1;
      half  <= 1'b0;
      txi   <= '0;
      word  <= 1'b0;
      cls   <= CL_BASIC;
      twc   <= '0;
    end else begin
      state <= state_d;
      half  <= half_d;
      txi   <= txi_d;
      word  <= word_d;
      cls   <= cls_d;
      twc   <= twc_d;
    end
  end

  // R2
  half_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half |=> !half);

  // R2
  state_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !half |=> $stable(state));

  // R8
  wait_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TS_TW && half && wait_n && twc >= wneed) |=> (state == TS_T2));
endmodule

// File: rtl/tseq_outs.sv
module tseq_outs
  import tseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  tstate_e          state,
  input  logic             half,
  input  logic [TX_W-1:0]  txi,
  input  logic             word,
  input  logic [CLS_W-1:0] cls,
  output logic             strobe,
  output logic             addr_inc,
  output logic             instr_end
);
  logic            tx_strobe;
  logic [TX_W-1:0] last_tx;

  assign tx_strobe = is_ctl(cls) && (tx_of(cls) != '0);
  assign last_tx   = tx_of(cls) - TX_W'(1);

  always_comb begin
    strobe    = (state == TS_T1) || (tx_strobe && state == TS_TX);
    addr_inc  = half && (tx_strobe ? (state == TS_TX && txi == last_tx)
                                   : (state == TS_T1));
    instr_end = half && (state == TS_T2) && ((cls != CL_DUAL) || word);
  end

  // R5
  addr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_inc |=> !addr_inc);

  // R4
  strobe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_inc |=> !strobe);

  // R10
  end_to_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_end |=> (state == TS_T1 && !half));
endmodule

// File: rtl/instr_tstate_seq.sv
module instr_tstate_seq
  import tseq_pkg::*;
#(
  parameter int WS_W   = 2,
  parameter int WS_RST = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CLS_W-1:0] instr_type,
  input  logic [WS_W-1:0]  iws_set,
  input  logic             wait_n,
  output logic [1:0]       tstate,
  output logic             half,
  output logic             instr_strobe,
  output logic             addr_inc,
  output logic             instr_end
);
  logic             rst_i_n;
  logic             capture, word;
  logic [WS_W-1:0]  wneed;
  logic [TX_W-1:0]  txi;
  logic [CLS_W-1:0] cls;
  tstate_e          state;

  tseq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  tseq_wait_sel #(.WS_W(WS_W), .WS_RST(WS_RST)) u_wsel (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .capture (capture),
    .cls_in  (instr_type),
    .ws_in   (iws_set),
    .wneed   (wneed)
  );

  tseq_core #(.WS_W(WS_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .cls_in  (instr_type),
    .wait_n  (wait_n),
    .wneed   (wneed),
    .state   (state),
    .half    (half),
    .txi     (txi),
    .word    (word),
    .cls     (cls),
    .capture (capture)
  );

  tseq_outs u_outs (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .state     (state),
    .half      (half),
    .txi       (txi),
    .word      (word),
    .cls       (cls),
    .strobe    (instr_strobe),
    .addr_inc  (addr_inc),
    .instr_end (instr_end)
  );

  assign tstate = state;
endmodule

// File: tb/instr_tstate_seq_bench.sv
`timescale 1ns/1ps
module instr_tstate_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] instr_type;
  logic [1:0] iws_set;
  logic       wait_n;
  logic [1:0] tstate;
  logic       half, instr_strobe, addr_inc, instr_end;

  int tests = 0;
  int fails = 0;
  bit cmp_en = 0;
  bit done = 0;

  always #10 clk = ~clk;

  instr_tstate_seq u_instr_tstate_seq (
    .clk (clk), .rst_n (rst_n), .instr_type (instr_type), .iws_set (iws_set),
    .wait_n (wait_n), .tstate (tstate), .half (half),
    .instr_strobe (instr_strobe), .addr_inc (addr_inc), .instr_end (instr_end)
  );

  // ---------------- behavioural reference: a queue of T-states per word
  int q[$];
  int pos, ph, word, sidx, cls, ws_prev, sync_cnt, m_tw;

  function automatic int n_tx(int c);
    if (c == 1 || c == 2) return 1;
    if (c == 3 || c == 4) return 2;
    return 0;
  endfunction

  function automatic bit ctl(int c);
    return (c == 1 || c == 4 || c == 5);
  endfunction

  function automatic int prog_tw(int c, int w);
    int t;
    t = w;
    if (c == 2) t = w - 1;
    if (c == 3) t = w - 2;
    return (t < 0) ? 0 : t;
  endfunction

  function automatic int exp_len(int c, int w);
    int words;
    words = (c == 5) ? 2 : 1;
    return 2 * words * (2 + n_tx(c) + prog_tw(c, w));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_cnt = 0; pos = 0; ph = 0; word = 0; ws_prev = 3;
      cls = 0; sidx = 0; m_tw = 0;
      q.delete(); q.push_back(0); q.push_back(3);
    end else if (sync_cnt < 2) begin
      sync_cnt++;
    end else if (ph == 0) begin
      if (pos == 0) begin
        if (word == 0) begin
          int eff;
          cls = (instr_type > 5) ? 0 : int'(instr_type);
          eff = ctl(cls) ? int'(iws_set) : ws_prev;
          ws_prev = int'(iws_set);
          m_tw = prog_tw(cls, eff);
        end
        q.delete();
        q.push_back(0);
        for (int i = 0; i < n_tx(cls); i++) q.push_back(1);
        for (int i = 0; i < m_tw; i++) q.push_back(2);
        q.push_back(3);
        sidx = (ctl(cls) && n_tx(cls) > 0) ? n_tx(cls) : 0;
      end
      ph = 1;
    end else begin
      if (q[pos] == 3) begin
        word = (cls == 5 && word == 0) ? 1 : 0;
        pos = 0;
      end else begin
        if (q[pos+1] == 3 && !wait_n) q.insert(pos + 1, 2);
        pos++;
      end
      ph = 0;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      int e_ts, e_stb, e_addr, e_end;
      e_ts   = q[pos];
      e_stb  = (pos <= sidx) ? 1 : 0;
      e_addr = (ph == 1 && pos == sidx) ? 1 : 0;
      e_end  = (ph == 1 && q[pos] == 3 && (cls != 5 || word == 1)) ? 1 : 0;
      tests++;
      if (int'(tstate) != e_ts) begin
        fails++;
        $display("FAIL R3/R6/R8/R11 tstate actual=%0d expected=%0d t=%0t", tstate, e_ts, $time);
      end else if (int'(half) != ph) begin
        fails++;
        $display("FAIL R2 half actual=%0d expected=%0d t=%0t", half, ph, $time);
      end else if (int'(instr_strobe) != e_stb) begin
        fails++;
        $display("FAIL R4 strobe actual=%0d expected=%0d t=%0t", instr_strobe, e_stb, $time);
      end else if (int'(addr_inc) != e_addr) begin
        fails++;
        $display("FAIL R5 addr_inc actual=%0d expected=%0d t=%0t", addr_inc, e_addr, $time);
      end else if (int'(instr_end) != e_end) begin
        fails++;
        $display("FAIL R10 instr_end actual=%0d expected=%0d t=%0t", instr_end, e_end, $time);
      end
    end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!instr_end);
  endtask

  initial begin
    int n;
    rst_n = 1'b0; instr_type = 3'd0; iws_set = 2'd0; wait_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs held in reset
    check("R1 reset tstate", int'(tstate), 0);
    check("R1 reset half/strobe/pulses",
          {half, instr_strobe, addr_inc, instr_end}, 4'b0100);
    cmp_en = 1;
    rst_n = 1'b1;
    // R1: first instruction uses the reset setting of 3: 2 sync cycles + 10 - 1
    measure(n);
    check("R1 first instr length", n, 11);
    // R9: second basic instruction uses the value sampled at the first start (0)
    measure(n);
    check("R9 second instr length", n, 4);

    // R3 R6 R7: length of every class under every setting
    for (int c = 0; c < 6; c++) begin
      for (int w = 0; w < 4; w++) begin
        instr_type = 3'(c); iws_set = 2'(w);
        measure(n); measure(n); measure(n);
        check($sformatf("R3 R6 R7 class %0d ws %0d length", c, w), n, exp_len(c, w));
      end
    end

    // R9: change in mid-instruction, data-path class sees it one instruction late
    instr_type = 3'd0; iws_set = 2'd0;
    measure(n); measure(n);
    @(negedge clk); @(negedge clk);
    iws_set = 2'd3;
    measure(n);
    measure(n);
    check("R9 basic keeps old setting", n, 4);
    measure(n);
    check("R9 basic sees new setting", n, 10);

    // R9: control class sees it on the very next instruction
    instr_type = 3'd1; iws_set = 2'd0;
    measure(n); measure(n);
    @(negedge clk); @(negedge clk);
    iws_set = 2'd3;
    measure(n);
    measure(n);
    check("R9 control uses new setting", n, 12);

    // R8: external wait held low for nine cycles on a three-state control
    iws_set = 2'd0;
    measure(n); measure(n);
    wait_n = 1'b0;
    n = 0;
    repeat (9) begin @(negedge clk); n++; end
    wait_n = 1'b1;
    while (!instr_end) begin @(negedge clk); n++; end
    check("R8 external wait length", n, 12);

    // R11 and mixed traffic: random class every cycle, wait bursts, setting moves
    repeat (4000) begin
      @(negedge clk);
      instr_type = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 19) == 0) iws_set = 2'($urandom_range(0, 3));
      wait_n = ($urandom_range(0, 5) != 0);
    end

    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule